// File: doc/BRIEF.md
# Serial Flash Ready Poller

This controller waits on a serial NOR flash until the flash is ready. When the host pulses `start`, it selects one of two readiness registers in the flash. It then reads that register again and again, each read in its own chip-select frame, until the returned byte reports that no internal operation is still running. The command and the returned byte can travel on one, two or four data lines. The host chooses the width with `mode`.

The first readiness register is the plain status register. There, ready means the busy flag in bit 0 reads 0. The second is the flag status register. There, ready means bit 7 reads 1. A flash built from four stacked dies only counts as finished when each die has answered ready. So an option asks for four ready flag reads in a row, each framed separately, before completion is reported. A timeout guards the whole wait. Between frames, chip select stays high for at least a set number of system clocks. The serial clock runs at half the system clock and idles low.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low: `cs_n` is 1, `sck` is 0, `dq_oe` is 0, and `done` and `busy` are 0.
- R2: Each frame starts with `cs_n` falling. It carries one opcode, sent most significant bit first: 0x05 when `reg_sel`=0 (status register) and 0x70 when `reg_sel`=1 (flag status register).
- R3: Width is set by `mode`: 2'b00 is one line, 2'b01 is two lines, 2'b10 is four lines, and 2'b11 behaves as 2'b00. On one line, the command leaves on DQ0 with `dq_oe`=4'b0001 and the reply is read from DQ1. On two lines, both use DQ[1:0] with `dq_oe`=4'b0011. On four lines, both use DQ[3:0] with `dq_oe`=4'b1111. A byte takes 8, 4 or 2 serial clocks. Bits change on the falling edge of `sck` and are captured on the rising edge.
- R4: Once the command has been sent, `dq_oe` is 0 for the rest of the frame.
- R5: With `reg_sel`=0, a reply whose bit 0 is 1 causes another frame. A reply whose bit 0 is 0 completes the poll.
- R6: With `reg_sel`=1, a reply whose bit 7 is 0 causes another frame. A reply whose bit 7 is 1 completes the poll.
- R7: With `reg_sel`=1 and `multi_die`=1, completion needs four ready replies in consecutive frames. A non-ready reply restarts that count from zero.
- R8: With `reg_sel`=0, `multi_die` has no effect: the first ready reply completes the poll.
- R9: `cs_n` is high for at least GAP_CYCLES system clocks before every frame, including the first.
- R10: If the poll has not completed within TIMEOUT_CYCLES clocks of `start`, the controller drops `busy`, raises `cs_n`, and sets `timeout_err` without pulsing `done`. `timeout_err` stays set until the next accepted `start`.
- R11: On completion, `done` is high for exactly one cycle. In that same cycle `busy` falls and `status_byte` holds the final reply byte.
- R12: A `start` pulse while `busy` is high is ignored. The running poll keeps its width, register and frame sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin polling |
| mode | input | 2 | Line width: 00 one, 01 two, 10 four |
| reg_sel | input | 1 | 0 status register, 1 flag status register |
| multi_die | input | 1 | Require four ready flag reads |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Poll aborted by timeout |
| status_byte | output | 8 | Most recent reply byte |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Data lines driven toward the flash |
| dq_oe | output | 4 | Per-line output enables |
| dq_in | input | 4 | Data lines driven by the flash |

## Verification
The assertions assume two things about the inputs. `rst` is held long enough for every register to settle. `dq_in` changes only while `sck` is low, as a flash does when it shifts data out on falling edges. The bench flash model follows both. It drives the reply only on falling `sck` edges, keeps `dq_in` at zero outside reply phases, and repeats the reply byte for as long as chip select stays low. The host inputs change half a cycle away from the active clock edge, and `start` is one cycle long.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    BM_ONE  = 2'b00,
    BM_TWO  = 2'b01,
    BM_FOUR = 2'b10,
    BM_ALT  = 2'b11
  } bus_mode_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_GAP,
    PS_CMD,
    PS_RESP,
    PS_EVAL
  } poll_state_e;

  function automatic logic [3:0] lane_mask(input bus_mode_e m);
    case (m)
      BM_TWO:  return 4'b0011;
      BM_FOUR: return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [2:0] last_clk(input bus_mode_e m);
    case (m)
      BM_TWO:  return 3'd3;
      BM_FOUR: return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/flash_poll_downcnt.sv
module flash_poll_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/flash_poll_shifter.sv
module flash_poll_shifter
  import flash_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      shift,
  input  bus_mode_e mode,
  input  logic [7:0] load_val,
  input  logic [3:0] din,
  output logic [3:0] lanes,
  output logic [7:0] data
);
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= load_val;
    else if (shift) begin
      case (mode)
        BM_TWO:  sr <= {sr[5:0], din[1:0]};
        BM_FOUR: sr <= {sr[3:0], din};
        default: sr <= {sr[6:0], din[1]};
      endcase
    end
  end

  always_comb begin
    case (mode)
      BM_TWO:  lanes = {2'b00, sr[7:6]};
      BM_FOUR: lanes = sr[7:4];
      default: lanes = {3'b000, sr[7]};
    endcase
  end

  assign data = sr;
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int         GAP_CYCLES     = 4,
  parameter int         TIMEOUT_CYCLES = 100000,
  parameter int         DIES           = 4,
  parameter logic [7:0] OP_STATUS      = 8'h05,
  parameter logic [7:0] OP_FLAG        = 8'h70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       reg_sel,
  input  logic       multi_die,
  output logic       busy,
  output logic       done,
  output logic       timeout_err,
  output logic [7:0] status_byte,
  output logic       cs_n,
  output logic       sck,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe,
  input  logic [3:0] dq_in
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int DW = (DIES > 1) ? $clog2(DIES) : 1;

  poll_state_e state;
  bus_mode_e   mode_q;
  logic        sel_q, md_q;
  logic [DW-1:0] die_q;
  logic [2:0]  bitc;
  logic        cs_q, sck_q, busy_q, done_q, err_q;
  logic [3:0]  oe_q;
  logic [7:0]  stat_q;

  logic gap_load, gap_dec, gap_zero;
  logic tmo_load, tmo_zero;
  logic sh_load, sh_shift;
  logic [3:0] lanes;
  logic [7:0] rx_byte;
  logic ready, final_ok, abort, last_bit;

  assign last_bit = (bitc == last_clk(mode_q));
  assign ready    = sel_q ? rx_byte[7] : ~rx_byte[0];
  assign final_ok = ready && (!(sel_q && md_q) || die_q == DW'(DIES - 1));
  assign abort    = busy_q && tmo_zero && !(state == PS_EVAL && final_ok);

  always_comb begin
    gap_load = ((state == PS_IDLE) && start) || ((state == PS_EVAL) && !final_ok);
    gap_dec  = (state == PS_GAP);
    tmo_load = (state == PS_IDLE) && start;
    sh_load  = (state == PS_GAP) && gap_zero && !abort;
    sh_shift = !abort && sck_q &&
               (((state == PS_CMD) && !last_bit) || (state == PS_RESP));
  end

  flash_poll_downcnt #(.W(GW)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load),
    .load_val(GW'(GAP_CYCLES - 1)), .dec(gap_dec), .zero(gap_zero)
  );

  flash_poll_downcnt #(.W(TW)) u_tmo (
    .clk(clk), .rst(rst), .load(tmo_load),
    .load_val(TW'(TIMEOUT_CYCLES - 1)), .dec(busy_q), .zero(tmo_zero)
  );

  flash_poll_shifter u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .shift(sh_shift), .mode(mode_q),
    .load_val(sel_q ? OP_FLAG : OP_STATUS), .din(dq_in),
    .lanes(lanes), .data(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_IDLE;
      mode_q <= BM_ONE;
      sel_q  <= 1'b0;
      md_q   <= 1'b0;
      die_q  <= '0;
      bitc   <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      oe_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        state  <= PS_IDLE;
        cs_q   <= 1'b1;
        sck_q  <= 1'b0;
        oe_q   <= '0;
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        case (state)
          PS_IDLE: if (start) begin
            mode_q <= bus_mode_e'(mode);
            sel_q  <= reg_sel;
            md_q   <= multi_die;
            die_q  <= '0;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            state  <= PS_GAP;
          end
          PS_GAP: if (gap_zero) begin
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
            oe_q  <= lane_mask(mode_q);
            bitc  <= '0;
            state <= PS_CMD;
          end
          PS_CMD: begin
            sck_q <= ~sck_q;
            if (sck_q) begin
              if (last_bit) begin
                oe_q  <= '0;
                bitc  <= '0;
                state <= PS_RESP;
              end else begin
                bitc <= bitc + 1'b1;
              end
            end
          end
          PS_RESP: begin
            sck_q <= ~sck_q;
            if (sck_q) begin
              if (last_bit) begin
                cs_q  <= 1'b1;
                state <= PS_EVAL;
              end else begin
                bitc <= bitc + 1'b1;
              end
            end
          end
          PS_EVAL: begin
            stat_q <= rx_byte;
            if (final_ok) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              state  <= PS_IDLE;
            end else begin
              die_q <= (ready && sel_q && md_q) ? die_q + 1'b1 : '0;
              state <= PS_GAP;
            end
          end
          default: state <= PS_IDLE;
        endcase
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign timeout_err = err_q;
  assign status_byte = stat_q;
  assign cs_n        = cs_q;
  assign sck         = sck_q;
  assign dq_oe       = oe_q;
  assign dq_out      = lanes & oe_q;
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker #(
  parameter int GAP_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       timeout_err,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] dq_oe
);
  localparam int HW = $clog2(GAP_CYCLES + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < HW'(GAP_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck && dq_oe == 4'b0000));

  assert_sck_framed_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  assert_lane_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

  assert_released_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && $past(dq_oe) == 4'b0000) |-> dq_oe == 4'b0000);

  assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt >= HW'(GAP_CYCLES));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!busy && cs_n));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_clean_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !timeout_err));
endmodule

bind flash_poll_ctrl flash_poll_checker #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .timeout_err(timeout_err),
  .cs_n(cs_n), .sck(sck), .dq_oe(dq_oe)
);

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
  localparam int GAP = 3;
  localparam int TMO = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic reg_sel = 1'b0;
  logic multi_die = 1'b0;
  logic busy, done, timeout_err, cs_n, sck;
  logic [7:0] status_byte;
  logic [3:0] dq_out, dq_oe;
  logic [3:0] dq_in = 4'b0000;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_sel(reg_sel),
    .multi_die(multi_die), .busy(busy), .done(done), .timeout_err(timeout_err),
    .status_byte(status_byte), .cs_n(cs_n), .sck(sck), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  typedef struct { int frames; logic [7:0] st; bit err; } exp_t;
  exp_t exp_q[$];

  logic [7:0] script[$];
  logic [1:0] cur_mode = 2'b00;
  logic       cur_sel  = 1'b0;
  int frames_seen = 0;

  function automatic logic [7:0] script_byte(input int k);
    if (k < script.size()) return script[k];
    return script[script.size() - 1];
  endfunction

  function automatic int width_of(input logic [1:0] m);
    if (m == 2'b01) return 2;
    if (m == 2'b10) return 4;
    return 1;
  endfunction

  // flash model: captures the command, then streams the reply byte repeatedly
  always begin
    int w, k;
    logic [7:0] opc, sh, resp;
    logic [3:0] emask;
    bit cut, mask_bad, oe_bad;
    @(negedge cs_n);
    k = frames_seen;
    frames_seen++;
    w = width_of(cur_mode);
    emask = (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0001;
    opc = '0; cut = 0; mask_bad = 0; oe_bad = 0;
    for (int i = 0; i < 8 / w; i++) begin
      @(posedge sck or posedge cs_n);
      if (cs_n) begin cut = 1; break; end
      if (w == 4)      opc = {opc[3:0], dq_out};
      else if (w == 2) opc = {opc[5:0], dq_out[1:0]};
      else             opc = {opc[6:0], dq_out[0]};
      if (dq_oe != emask) mask_bad = 1;
    end
    if (!cut) begin
      check(opc == (cur_sel ? 8'h70 : 8'h05), "R2 opcode", opc, cur_sel ? 8'h70 : 8'h05);
      check(!mask_bad, "R3 command lane enables", 0, 0);
      resp = script_byte(k);
      sh = resp;
      forever begin
        @(negedge sck or posedge cs_n);
        if (cs_n) break;
        if (dq_oe != 4'b0000) oe_bad = 1;
        if (w == 4)      begin dq_in = sh[7:4];                sh = {sh[3:0], sh[7:4]}; end
        else if (w == 2) begin dq_in = {2'b00, sh[7:6]};       sh = {sh[5:0], sh[7:6]}; end
        else             begin dq_in = {2'b00, sh[7], 1'b0};   sh = {sh[6:0], sh[7]};   end
      end
      check(!oe_bad, "R4 lines released in reply", 0, 0);
    end
    dq_in = 4'b0000;
  end

  // chip-select high time before each frame
  int  hi_run = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_n && cs_prev)
        check(hi_run >= GAP, "R9 cs_n high time", hi_run, GAP);
      hi_run = cs_n ? hi_run + 1 : 0;
    end
    cs_prev = cs_n;
  end

  // scoreboard monitor
  logic err_d = 1'b0;
  always @(negedge clk) begin
    if (!rst && (done || (timeout_err && !err_d))) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check(0, "R11 unexpected completion", 0, 1);
      end else begin
        e = exp_q.pop_front();
        check(timeout_err == e.err, e.err ? "R10 timeout flag" : "R11 no timeout", timeout_err, e.err);
        check(done == !e.err, e.err ? "R10 no done on abort" : "R11 done pulse", done, !e.err);
        check(status_byte == e.st, "R11 status byte", status_byte, e.st);
        if (e.frames >= 0)
          check(frames_seen == e.frames, "R5 R6 R7 R8 R12 frame count", frames_seen, e.frames);
        check(!busy && cs_n, "R10 R11 idle after end", {busy, cs_n}, 2'b01);
      end
    end
    err_d = timeout_err;
  end

  task automatic run_poll(input logic [1:0] m, input logic sel, input logic md,
                          input int nfr, input logic [7:0] st, input bit er, input bit poke);
    cur_mode = m;
    cur_sel = sel;
    frames_seen = 0;
    exp_q.push_back('{nfr, st, er});
    @(negedge clk);
    mode = m; reg_sel = sel; multi_die = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && timeout_err == 1'b0, "R10 R12 busy after start", {busy, timeout_err}, 2'b10);
    if (poke) begin
      repeat (10) @(negedge clk);
      mode = 2'b10; reg_sel = ~sel; start = 1'b1;   // R12: must be ignored
      @(negedge clk);
      start = 1'b0; mode = m; reg_sel = sel;
    end
    while (!(done || timeout_err)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 reset bus idle", {cs_n, sck}, 2'b10);
    check(dq_oe == 4'b0000, "R1 reset enables", dq_oe, 0);
    check(!busy && !done && !timeout_err, "R1 reset flags", {busy, done, timeout_err}, 0);

    // R5 + R12: status register on one line, busy bit clears on third reply
    script = '{8'h01, 8'h03, 8'h02};
    run_poll(2'b00, 1'b0, 1'b0, 3, 8'h02, 0, 1);

    // R6: flag register on two lines
    script = '{8'h7F, 8'h81};
    run_poll(2'b01, 1'b1, 1'b0, 2, 8'h81, 0, 0);

    // R7: four dies, four lines, all ready
    script = '{8'h80, 8'h80, 8'h80, 8'h80};
    run_poll(2'b10, 1'b1, 1'b1, 4, 8'h80, 0, 0);

    // R7: not-ready reply restarts the die count
    script = '{8'h80, 8'h80, 8'h00, 8'h80, 8'h80, 8'h80, 8'hC0};
    run_poll(2'b10, 1'b1, 1'b1, 7, 8'hC0, 0, 0);

    // R8: multi-die ignored for the status register
    script = '{8'h00};
    run_poll(2'b01, 1'b0, 1'b1, 1, 8'h00, 0, 0);

    // R3: reserved mode acts as one line
    script = '{8'hFE};
    run_poll(2'b11, 1'b0, 1'b0, 1, 8'hFE, 0, 0);

    // R10: never ready, timeout abort
    script = '{8'h00};
    run_poll(2'b10, 1'b1, 1'b0, -1, 8'h00, 1, 0);
    check(timeout_err == 1'b1, "R10 flag held", timeout_err, 1);

    // R10: flag cleared by next start
    script = '{8'h80};
    run_poll(2'b00, 1'b1, 1'b0, 1, 8'h80, 0, 0);

    check(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule